// File: doc/BRIEF.md
# Smart Card Character Transceiver

This block moves single characters in both directions over the one bidirectional data line of an asynchronous IC-card link, one direction at a time. In card mode a character is a low start bit, eight data bits and a parity bit, followed by a released guard period of two bit times. Two controls map the stored byte onto the line so that either card coding convention can be served. One control reverses the bit order and the other inverts every data and parity level. A third control picks the parity sense. With card mode off, the block sends plain serial characters with no parity and one stop period.

The line is modelled as open drain. The block asserts `io_oe` to pull the line low and releases it for a high level. The pulled-up line level comes back on `io_in`. Bit time is a run-time count of system clocks. The receiver locates each bit by sampling at mid-period after the falling start edge. A host loads bytes through a write strobe and collects them through a read strobe. It watches five flags: transmit-data-empty, receive-data-full, overrun, parity error and transmit-end. A gated card clock output either toggles every system clock or rests at a fixed level.

Top module: `sc_char_xcvr`

## Requirements
- R1: After reset, tdre=1, tend=1, rdrf=0, overrun=0, parity_err=0 and io_oe=0.
- R2: In card mode with cfg_msb_first=0 and cfg_invert=0, a character goes out as a low start bit, then data bits 0..7 in that order, then the parity bit, then at least two released bit periods. Each bit lasts cfg_etu clocks. A low level is io_oe=1 and a high level is io_oe=0.
- R3: The logical parity bit equals XOR of the eight data bits XOR cfg_parity_odd, so 0x3B with cfg_parity_odd=0 carries parity 1.
- R4: In card mode with cfg_msb_first=1 and cfg_invert=1, data goes out bit 7 first and every data and parity level is inverted on the line. The start bit stays low.
- R5: With cfg_card_mode=0, a character is a start bit, data bits 0..7 at their true levels, and one released stop period. There is no parity bit, and cfg_msb_first and cfg_invert have no effect.
- R6: A tx_write pulse stores tx_data and clears tdre and tend in the next cycle. When the transmitter is idle it takes the byte one cycle later, and tdre returns to 1.
- R7: If tdre=1 when a frame finishes, tend is set. With cfg_tend_mode=0 this happens at the end of the guard period. With cfg_tend_mode=1 it happens at the end of the parity bit.
- R8: The receiver samples each bit near mid-period and undoes the same bit-order and inversion mapping. It places the byte on rx_data and sets rdrf. An rx_read pulse clears rdrf, overrun and parity_err.
- R9: When the received parity does not match the R3 rule, parity_err is set and the byte is still delivered.
- R10: A character that completes while rdrf=1 sets overrun and leaves rx_data holding the earlier byte.
- R11: While the transmitter is busy the receiver ignores the line, so the block's own transmission is never received.
- R12: With cfg_clk_en=1, card_clk toggles on every system clock. With cfg_clk_en=0, it rests at the level of cfg_tend_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_card_mode | input | 1 | 1: card framing with parity; 0: plain serial framing |
| cfg_msb_first | input | 1 | Bit-order reversal in card mode |
| cfg_invert | input | 1 | Line level inversion of data and parity in card mode |
| cfg_parity_odd | input | 1 | Parity sense added to the data XOR |
| cfg_tend_mode | input | 1 | Transmit-end timing select; also the card clock rest level |
| cfg_clk_en | input | 1 | Card clock output enable |
| cfg_etu | input | ETU_W | System clocks per bit period (at least 2) |
| tx_data | input | 8 | Byte to send |
| tx_write | input | 1 | Write strobe for tx_data |
| rx_read | input | 1 | Read strobe acknowledging the received byte |
| io_in | input | 1 | Level of the pulled-up card data line |
| io_oe | output | 1 | Pull the card data line low |
| card_clk | output | 1 | Clock to the card |
| rx_data | output | 8 | Last delivered received byte |
| tdre | output | 1 | Transmit buffer empty |
| rdrf | output | 1 | Received byte waiting |
| overrun | output | 1 | Character lost while rdrf was set |
| parity_err | output | 1 | Parity mismatch on the delivered byte |
| tend | output | 1 | Transmission finished with empty buffer |

## Verification
The bench keeps the default ETU_W of 10. It sets the bit period at run time to 16 clocks and to 7 clocks, so the odd, truncated half-period sample point is tried as well as the even one. Short periods let whole frames in both conventions, the plain serial frame, both transmit-end timings, a parity error and an overrun pair fit in a few thousand cycles. The bench wires the data line as open drain back to `io_in`, so every transmitted frame also tests that the receiver stays quiet.

// File: rtl/sc_pkg.sv
package sc_pkg;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_PAR,
    TX_GUARD
  } tx_ph_t;

  // Map a byte to line order and level; the map is its own inverse.
  function automatic logic [7:0] sc_line_order(input logic [7:0] d,
                                               input logic rev,
                                               input logic inv);
    logic [7:0] o;
    for (int i = 0; i < 8; i++) begin
      o[i] = (rev ? d[7-i] : d[i]) ^ inv;
    end
    return o;
  endfunction

endpackage

// File: rtl/sc_etu_cnt.sv
module sc_etu_cnt #(
  parameter int ETU_W    = 10,
  parameter bit MID_TICK = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [ETU_W-1:0] etu,
  output logic             tick
);
  localparam logic [ETU_W-1:0] ONE_C = ETU_W'(1);

  logic [ETU_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = run && (cnt_q == etu - ONE_C);

  generate
    if (MID_TICK) begin : g_mid
      assign tick = run && (cnt_q == (etu >> 1));
    end else begin : g_end
      assign tick = wrap;
    end
  endgenerate

  always_comb begin
    if (!run || wrap) cnt_d = '0;
    else              cnt_d = cnt_q + ONE_C;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  etu_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < etu));

endmodule

// File: rtl/sc_tx.sv
module sc_tx import sc_pkg::*; #(
  parameter int ETU_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             card_mode,
  input  logic             msb_first,
  input  logic             invert,
  input  logic             parity_odd,
  input  logic             tend_mode,
  input  logic [ETU_W-1:0] etu,
  input  logic [7:0]       tx_data,
  input  logic             tx_write,
  output logic             io_oe,
  output logic             busy,
  output logic             tdre,
  output logic             tend
);
  tx_ph_t     ph_q, ph_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] shf_q, shf_d;
  logic [7:0] hold_q, hold_d;
  logic       par_q, par_d;
  logic       last_q, last_d;
  logic       tdre_q, tdre_d;
  logic       tend_q, tend_d;
  logic       tick;
  logic       lvl;

  sc_etu_cnt #(.ETU_W(ETU_W), .MID_TICK(1'b0)) u_bit_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (ph_q != TX_IDLE),
    .etu  (etu),
    .tick (tick)
  );

  always_comb begin
    ph_d   = ph_q;
    bit_d  = bit_q;
    shf_d  = shf_q;
    hold_d = hold_q;
    par_d  = par_q;
    last_d = last_q;
    tdre_d = tdre_q;
    tend_d = tend_q;
    case (ph_q)
      TX_IDLE: if (!tdre_q) begin
        shf_d  = sc_line_order(hold_q, msb_first & card_mode, invert & card_mode);
        par_d  = (^hold_q) ^ parity_odd ^ invert;
        bit_d  = 3'd0;
        ph_d   = TX_START;
        tdre_d = 1'b1;
      end
      TX_START: if (tick) ph_d = TX_DATA;
      TX_DATA: if (tick) begin
        shf_d = {1'b1, shf_q[7:1]};
        bit_d = bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          ph_d   = card_mode ? TX_PAR : TX_GUARD;
          last_d = !card_mode;
          if (!card_mode && tend_mode && tdre_q) tend_d = 1'b1;
        end
      end
      TX_PAR: if (tick) begin
        ph_d   = TX_GUARD;
        last_d = 1'b0;
        if (tend_mode && tdre_q) tend_d = 1'b1;
      end
      TX_GUARD: if (tick) begin
        if (last_q) begin
          ph_d = TX_IDLE;
          if (!tend_mode && tdre_q) tend_d = 1'b1;
        end else begin
          last_d = 1'b1;
        end
      end
      default: ph_d = TX_IDLE;
    endcase
    if (tx_write) begin
      hold_d = tx_data;
      tdre_d = 1'b0;
      tend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= TX_IDLE;
      bit_q  <= '0;
      shf_q  <= '1;
      hold_q <= '0;
      par_q  <= 1'b1;
      last_q <= 1'b0;
      tdre_q <= 1'b1;
      tend_q <= 1'b1;
    end else begin
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      shf_q  <= shf_d;
      hold_q <= hold_d;
      par_q  <= par_d;
      last_q <= last_d;
      tdre_q <= tdre_d;
      tend_q <= tend_d;
    end
  end

  always_comb begin
    case (ph_q)
      TX_START: lvl = 1'b0;
      TX_DATA:  lvl = shf_q[0];
      TX_PAR:   lvl = par_q;
      default:  lvl = 1'b1;
    endcase
  end

  assign io_oe = !lvl;
  assign busy  = (ph_q != TX_IDLE);
  assign tdre  = tdre_q;
  assign tend  = tend_q;

  // R6
  tdre_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_write |=> !tdre);

  // R7
  tend_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tend) |-> !$past(tx_write));

endmodule

// File: rtl/sc_rx.sv
module sc_rx import sc_pkg::*; #(
  parameter int ETU_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             card_mode,
  input  logic             msb_first,
  input  logic             invert,
  input  logic             parity_odd,
  input  logic [ETU_W-1:0] etu,
  input  logic             io_in,
  input  logic             tx_busy,
  input  logic             rx_read,
  output logic [7:0]       rx_data,
  output logic             rdrf,
  output logic             overrun,
  output logic             parity_err,
  output logic             done
);
  logic [2:0] sync_q;
  logic       act_q, act_d;
  logic [3:0] idx_q, idx_d;
  logic [7:0] dsh_q, dsh_d;
  logic [7:0] data_q, data_d;
  logic       rdrf_q, rdrf_d, ovr_q, ovr_d, perr_q, perr_d;
  logic       tick;
  logic [7:0] full_c, byte_c;
  logic       perr_c;
  logic [3:0] last_idx;

  sc_etu_cnt #(.ETU_W(ETU_W), .MID_TICK(1'b1)) u_smp_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (act_q),
    .etu  (etu),
    .tick (tick)
  );

  assign full_c   = {sync_q[1], dsh_q[7:1]};
  assign last_idx = card_mode ? 4'd9 : 4'd8;
  assign byte_c   = card_mode ? sc_line_order(dsh_q, msb_first, invert) : full_c;
  assign perr_c   = card_mode & ((sync_q[1] ^ invert) != ((^byte_c) ^ parity_odd));

  always_comb begin
    act_d  = act_q;
    idx_d  = idx_q;
    dsh_d  = dsh_q;
    data_d = data_q;
    rdrf_d = rdrf_q;
    ovr_d  = ovr_q;
    perr_d = perr_q;
    done   = 1'b0;
    if (!act_q) begin
      if (!tx_busy && sync_q[2] && !sync_q[1]) begin
        act_d = 1'b1;
        idx_d = 4'd0;
      end
    end else if (tx_busy) begin
      act_d = 1'b0;
    end else if (tick) begin
      idx_d = idx_q + 4'd1;
      if (idx_q == 4'd0) begin
        if (sync_q[1]) act_d = 1'b0;
      end else if (idx_q <= 4'd8) begin
        dsh_d = full_c;
      end
      if (idx_q == last_idx) begin
        act_d = 1'b0;
        done  = 1'b1;
      end
    end
    if (done) begin
      if (rdrf_q) begin
        ovr_d = 1'b1;
      end else begin
        data_d = byte_c;
        rdrf_d = 1'b1;
        perr_d = perr_c;
      end
    end else if (rx_read) begin
      rdrf_d = 1'b0;
      ovr_d  = 1'b0;
      perr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 3'b111;
      act_q  <= 1'b0;
      idx_q  <= '0;
      dsh_q  <= '0;
      data_q <= '0;
      rdrf_q <= 1'b0;
      ovr_q  <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], io_in};
      act_q  <= act_d;
      idx_q  <= idx_d;
      dsh_q  <= dsh_d;
      data_q <= data_d;
      rdrf_q <= rdrf_d;
      ovr_q  <= ovr_d;
      perr_q <= perr_d;
    end
  end

  assign rx_data    = data_q;
  assign rdrf       = rdrf_q;
  assign overrun    = ovr_q;
  assign parity_err = perr_q;

  // R10
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rdrf));

  // R8
  rdrf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_read && !done) |=> !rdrf);

endmodule

// File: rtl/sc_char_xcvr.sv
module sc_char_xcvr #(
  parameter int ETU_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_card_mode,
  input  logic             cfg_msb_first,
  input  logic             cfg_invert,
  input  logic             cfg_parity_odd,
  input  logic             cfg_tend_mode,
  input  logic             cfg_clk_en,
  input  logic [ETU_W-1:0] cfg_etu,
  input  logic [7:0]       tx_data,
  input  logic             tx_write,
  input  logic             rx_read,
  input  logic             io_in,
  output logic             io_oe,
  output logic             card_clk,
  output logic [7:0]       rx_data,
  output logic             tdre,
  output logic             rdrf,
  output logic             overrun,
  output logic             parity_err,
  output logic             tend
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  logic       tx_busy;
  logic       rx_done;
  logic       ck_q, ck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  sc_tx #(.ETU_W(ETU_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_ni),
    .card_mode (cfg_card_mode),
    .msb_first (cfg_msb_first),
    .invert    (cfg_invert),
    .parity_odd(cfg_parity_odd),
    .tend_mode (cfg_tend_mode),
    .etu       (cfg_etu),
    .tx_data   (tx_data),
    .tx_write  (tx_write),
    .io_oe     (io_oe),
    .busy      (tx_busy),
    .tdre      (tdre),
    .tend      (tend)
  );

  sc_rx #(.ETU_W(ETU_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_ni),
    .card_mode (cfg_card_mode),
    .msb_first (cfg_msb_first),
    .invert    (cfg_invert),
    .parity_odd(cfg_parity_odd),
    .etu       (cfg_etu),
    .io_in     (io_in),
    .tx_busy   (tx_busy),
    .rx_read   (rx_read),
    .rx_data   (rx_data),
    .rdrf      (rdrf),
    .overrun   (overrun),
    .parity_err(parity_err),
    .done      (rx_done)
  );

  always_comb ck_d = cfg_clk_en ? !ck_q : cfg_tend_mode;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ck_q <= 1'b0;
    else         ck_q <= ck_d;
  end
  assign card_clk = ck_q;

  // R11
  half_duplex_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    tx_busy |-> !rx_done);

  // R12
  clk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_clk_en && $past(cfg_clk_en)) |-> (card_clk != $past(card_clk)));

endmodule

// File: tb/sc_char_xcvr_tb.sv
`timescale 1ns/1ps
module sc_char_xcvr_tb;
  localparam int ETU_W = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_card_mode, cfg_msb_first, cfg_invert, cfg_parity_odd;
  logic             cfg_tend_mode, cfg_clk_en;
  logic [ETU_W-1:0] cfg_etu;
  logic [7:0]       tx_data;
  logic             tx_write, rx_read;
  logic             drv_line;
  logic             io_in, io_oe, card_clk;
  logic [7:0]       rx_data;
  logic             tdre, rdrf, overrun, parity_err, tend;

  int n_chk  = 0;
  int n_fail = 0;
  int etu_i  = 16;
  logic [11:0] exp_q[$];
  int          len_q[$];

  always #4 clk = ~clk;

  assign io_in = drv_line & ~io_oe;

  sc_char_xcvr #(.ETU_W(ETU_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_card_mode(cfg_card_mode), .cfg_msb_first(cfg_msb_first),
    .cfg_invert(cfg_invert), .cfg_parity_odd(cfg_parity_odd),
    .cfg_tend_mode(cfg_tend_mode), .cfg_clk_en(cfg_clk_en),
    .cfg_etu(cfg_etu), .tx_data(tx_data), .tx_write(tx_write),
    .rx_read(rx_read), .io_in(io_in), .io_oe(io_oe), .card_clk(card_clk),
    .rx_data(rx_data), .tdre(tdre), .rdrf(rdrf), .overrun(overrun),
    .parity_err(parity_err), .tend(tend)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [7:0] line_map(input logic [7:0] d, input logic rev, input logic inv);
    logic [7:0] o;
    for (int i = 0; i < 8; i++) o[i] = (rev ? d[7-i] : d[i]) ^ inv;
    return o;
  endfunction

  // frame levels: [0] start, [8:1] data in line order, [9] parity
  function automatic logic [11:0] mk_frame(input logic [7:0] d);
    logic [11:0] f;
    logic        cm;
    cm = cfg_card_mode;
    f = 12'hfff;
    f[0] = 1'b0;
    f[8:1] = line_map(d, cfg_msb_first & cm, cfg_invert & cm);
    if (cm) f[9] = (^d) ^ cfg_parity_odd ^ cfg_invert;
    return f;
  endfunction

  task automatic send_byte(input logic [7:0] d);
    exp_q.push_back(mk_frame(d));
    len_q.push_back(cfg_card_mode ? 10 : 9);
    @(negedge clk);
    tx_data  = d;
    tx_write = 1'b1;
    @(negedge clk);
    tx_write = 1'b0;
    chk("R6 tdre after write", tdre, 1'b0);
    chk("R6 tend after write", tend, 1'b0);
    @(negedge clk);
    chk("R6 tdre after load", tdre, 1'b1);
  endtask

  task automatic rx_frame(input logic [7:0] d, input logic bad_par);
    logic [11:0] f;
    int          nb;
    f  = mk_frame(d);
    nb = cfg_card_mode ? 10 : 9;
    if (bad_par) f[9] = ~f[9];
    for (int b = 0; b < nb; b++) begin
      drv_line = f[b];
      repeat (etu_i) @(negedge clk);
    end
    drv_line = 1'b1;
    repeat (2 * etu_i + 4) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk);
    rx_read = 1'b1;
    @(negedge clk);
    rx_read = 1'b0;
  endtask

  // monitor: decode each transmitted frame and compare with the queue
  initial begin
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && io_oe && !prev) begin
        logic [11:0] ef;
        int          n;
        logic [11:0] got;
        got = 12'hfff;
        if (exp_q.size() == 0) begin
          chk("R2 unexpected frame", 1, 0);
          ef = 12'hfff;
          n  = 10;
        end else begin
          ef = exp_q.pop_front();
          n  = len_q.pop_front();
        end
        repeat (etu_i / 2) @(negedge clk);
        for (int b = 0; b < n; b++) begin
          got[b] = !io_oe;
          if (b < n - 1) repeat (etu_i) @(negedge clk);
        end
        // R2 R3 R4 R5: whole frame on the line
        chk("R2/R3/R4/R5 line frame", got, ef);
        prev = io_oe;
      end else begin
        prev = io_oe;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog", 0, 1);
    report();
  end

  initial begin
    rst_n = 1'b0;
    cfg_card_mode = 1'b1; cfg_msb_first = 1'b0; cfg_invert = 1'b0;
    cfg_parity_odd = 1'b0; cfg_tend_mode = 1'b0; cfg_clk_en = 1'b0;
    cfg_etu = ETU_W'(16); etu_i = 16;
    tx_data = 8'h00; tx_write = 1'b0; rx_read = 1'b0; drv_line = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 tdre", tdre, 1'b1);
    chk("R1 tend", tend, 1'b1);
    chk("R1 rdrf", rdrf, 1'b0);
    chk("R1 overrun", overrun, 1'b0);
    chk("R1 parity_err", parity_err, 1'b0);
    chk("R1 io_oe", io_oe, 1'b0);

    // R2 R3 direct convention, 0x3B parity 1; R7 tend at guard end
    send_byte(8'h3B);
    repeat (10 * etu_i + etu_i / 2) @(negedge clk);
    chk("R7 tend mode0 mid guard", tend, 1'b0);
    repeat (2 * etu_i) @(negedge clk);
    chk("R7 tend mode0 after guard", tend, 1'b1);
    repeat (4) @(negedge clk);

    // R4 inverse convention; R7 tend at parity end
    cfg_msb_first = 1'b1; cfg_invert = 1'b1; cfg_parity_odd = 1'b1; cfg_tend_mode = 1'b1;
    send_byte(8'h3B);
    repeat (10 * etu_i + etu_i / 2) @(negedge clk);
    chk("R7 tend mode1 mid guard", tend, 1'b1);
    repeat (2 * etu_i + 4) @(negedge clk);

    // R5 plain serial framing, order and inversion ignored
    cfg_card_mode = 1'b0; cfg_tend_mode = 1'b0;
    cfg_etu = ETU_W'(7); etu_i = 7;
    send_byte(8'hA5);
    repeat (12 * etu_i) @(negedge clk);
    chk("R5 tend after plain frame", tend, 1'b1);

    // R11 own transmissions were not received
    chk("R11 rdrf after own tx", rdrf, 1'b0);
    chk("R11 overrun after own tx", overrun, 1'b0);

    // R8 receive direct convention
    cfg_card_mode = 1'b1; cfg_msb_first = 1'b0; cfg_invert = 1'b0; cfg_parity_odd = 1'b0;
    cfg_etu = ETU_W'(16); etu_i = 16;
    rx_frame(8'h3B, 1'b0);
    chk("R8 rdrf set", rdrf, 1'b1);
    chk("R8 rx_data", rx_data, 8'h3B);
    chk("R8 no parity_err", parity_err, 1'b0);
    do_read();
    chk("R8 rdrf cleared by read", rdrf, 1'b0);

    // R9 inverse convention, odd etu, wrong parity still delivers
    cfg_msb_first = 1'b1; cfg_invert = 1'b1; cfg_parity_odd = 1'b1;
    cfg_etu = ETU_W'(7); etu_i = 7;
    rx_frame(8'hC4, 1'b1);
    chk("R9 parity_err set", parity_err, 1'b1);
    chk("R9 rx_data delivered", rx_data, 8'hC4);
    chk("R9 rdrf set", rdrf, 1'b1);
    do_read();
    chk("R8 parity_err cleared by read", parity_err, 1'b0);
    rx_frame(8'h5E, 1'b0);
    chk("R8 inverse rx_data", rx_data, 8'h5E);
    chk("R8 inverse parity ok", parity_err, 1'b0);
    do_read();

    // R10 overrun keeps first byte
    rx_frame(8'h11, 1'b0);
    rx_frame(8'h22, 1'b0);
    chk("R10 overrun set", overrun, 1'b1);
    chk("R10 rx_data kept", rx_data, 8'h11);
    do_read();
    chk("R8 overrun cleared by read", overrun, 1'b0);

    // R12 card clock
    cfg_clk_en = 1'b1;
    repeat (2) @(negedge clk);
    begin
      logic pv;
      int   tg;
      pv = card_clk;
      tg = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (card_clk != pv) tg++;
        pv = card_clk;
      end
      chk("R12 toggles when enabled", tg, 10);
    end
    cfg_clk_en = 1'b0; cfg_tend_mode = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 rest level 1", card_clk, 1'b1);
    cfg_tend_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 rest level 0", card_clk, 1'b0);

    chk("R2 all frames seen", exp_q.size(), 0);
    report();
  end

endmodule